// File: doc/BRIEF.md
# Reloadable 24-bit DMA Transfer Counter

This block holds the byte count for a DMA transfer. Software loads a start count one byte at a time through three byte-wide register addresses. The same addresses read back the live current count. A command strobe with its DMA flag set copies the start count into the current count. The surrounding transfer engine then asks for decrements of any size as bytes move. When the transfer finishes, the engine forces the count to zero.

A terminal-count status bit is set whenever the count is driven to zero, either by a decrement or by a completion. Any software write to a count byte clears that bit. A start count of zero reloads as 65536, so the full-range transfer can be expressed with a zero start value.

The top-byte read address returns a fixed identification constant until software writes that byte for the first time after reset. A software probe can use this to tell the part apart from a plain counter. The block has no bus protocol of its own: writes are single-cycle strobes, and reads are combinational from an address.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset both counts are zero, the terminal-count flag and the DMA-mode flag are 0, and the zero flag is 1.
- R2: A write to count address 0 (bits 7:0), 1 (bits 15:8) or 2 (bits 23:16) updates only the start count; the current count does not change.
- R3: A command strobe with the DMA flag set copies the start count into the current count on the next clock edge and sets DMA mode to 1.
- R4: When a DMA command is given with a start count of zero, the current count becomes 0x010000.
- R5: A command strobe without the DMA flag sets DMA mode to 0 and leaves the current count unchanged.
- R6: A write to any of the three count addresses clears the terminal-count flag.
- R7: Until address 2 has been written once after reset, a read of address 2 returns the identification constant 0xA2. After that write, it returns bits 23:16 of the current count.
- R8: A decrement request with an amount below the current count subtracts that amount. A decrement that lands exactly on zero sets the terminal-count flag.
- R9: A decrement amount larger than the current count leaves the count at zero and sets the terminal-count flag.
- R10: A completion request forces the current count to zero and sets the terminal-count flag.
- R11: When requests coincide in one cycle, completion wins over a DMA reload, and a DMA reload wins over a decrement. A terminal-count set in that cycle wins over a clear caused by a count write.
- R12: The zero flag is 1 exactly when the current count is zero.
- R13: A read of address 3, which is not a count byte, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hard reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register write address |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 2 | Register read address |
| regRdData | output | 8 | Register read data (combinational) |
| cmdStrobe | input | 1 | Command issued this cycle |
| cmdDmaFlag | input | 1 | DMA flag of the issued command |
| decReq | input | 1 | Decrement request |
| decAmount | input | 24 | Decrement amount |
| doneReq | input | 1 | Transfer completion |
| curCount | output | 24 | Current count |
| countZero | output | 1 | Current count is zero |
| tcFlag | output | 1 | Terminal-count status bit |
| dmaMode | output | 1 | DMA mode of the last command |

## Verification
The directed patterns each isolate one path:
- Byte-wise loads followed by a DMA reload tell the start-count storage apart from the live count.
- A zero start count exposes the 65536 substitution.
- Exact, short and oversized decrements separate subtraction from saturation.
- Coincident completion, reload, decrement and count-write requests pin down the priority order and the terminal-count set-versus-clear rule.

A seeded random mix of all requests then compares every output against a bench model cycle by cycle. The high-byte read is checked both before and after its first write, including after a second reset.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic startWe;    // write a start-count byte
    logic reload;     // copy start count into current count
    logic dec;        // apply a decrement
    logic forceZero;  // completion: clear current count
  } xfer_strobe_t;
endpackage

// File: rtl/xfer_cnt_ctrl.sv
module xfer_cnt_ctrl
  import xfer_cnt_pkg::*;
#(
  parameter int COUNT_BYTES = 3,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              cmdStrobe,
  input  logic              cmdDmaFlag,
  input  logic              decReq,
  input  logic              doneReq,
  input  logic              decHitsZero,
  output xfer_strobe_t      strobe,
  output logic              tcFlag,
  output logic              dmaMode,
  output logic              highWritten
);
  localparam int TOP_IDX = COUNT_BYTES - 1;

  logic isCountAddr;
  logic isTopAddr;
  logic setTc;

  assign isCountAddr = (32'(regAddr) < COUNT_BYTES);
  assign isTopAddr   = (32'(regAddr) == TOP_IDX);

  always_comb begin
    strobe.startWe   = regWrEn && isCountAddr;
    strobe.forceZero = doneReq;
    strobe.reload    = cmdStrobe && cmdDmaFlag && !doneReq;
    strobe.dec       = decReq && !doneReq && !(cmdStrobe && cmdDmaFlag);
  end

  assign setTc = strobe.forceZero || (strobe.dec && decHitsZero);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tcFlag      <= 1'b0;
      dmaMode     <= 1'b0;
      highWritten <= 1'b0;
    end else begin
      if (setTc)               tcFlag <= 1'b1;
      else if (strobe.startWe) tcFlag <= 1'b0;
      if (cmdStrobe) dmaMode <= cmdDmaFlag;
      if (strobe.startWe && isTopAddr) highWritten <= 1'b1;
    end
  end
endmodule

// File: rtl/xfer_cnt_dp.sv
module xfer_cnt_dp
  import xfer_cnt_pkg::*;
#(
  parameter int         COUNT_BYTES = 3,
  parameter int         ADDR_W      = 2,
  parameter logic [7:0] CHIP_ID     = 8'hA2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xfer_strobe_t             strobe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [7:0]               regWrData,
  input  logic [ADDR_W-1:0]        regRdAddr,
  input  logic [COUNT_BYTES*8-1:0] decAmount,
  input  logic                     highWritten,
  output logic [7:0]               regRdData,
  output logic [COUNT_BYTES*8-1:0] curCount,
  output logic [COUNT_BYTES*8-1:0] startCount,
  output logic                     decHitsZero
);
  localparam int CNT_W   = COUNT_BYTES * 8;
  localparam int TOP_IDX = COUNT_BYTES - 1;
  localparam logic [CNT_W-1:0] ZERO_RELOAD = CNT_W'(1) << (CNT_W - 8);

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] nextCount;

  for (genvar b = 0; b < COUNT_BYTES; b++) begin : g_start
    always_ff @(posedge clk) begin
      if (!rstN)
        startCount[b*8 +: 8] <= 8'h00;
      else if (strobe.startWe && (32'(regAddr) == b))
        startCount[b*8 +: 8] <= regWrData;
    end
  end

  assign reloadVal   = (startCount == '0) ? ZERO_RELOAD : startCount;
  assign decHitsZero = (decAmount >= curCount);

  always_comb begin
    nextCount = curCount;
    if (strobe.forceZero)   nextCount = '0;
    else if (strobe.reload) nextCount = reloadVal;
    else if (strobe.dec)    nextCount = decHitsZero ? '0 : (curCount - decAmount);
  end

  always_ff @(posedge clk) begin
    if (!rstN) curCount <= '0;
    else       curCount <= nextCount;
  end

  always_comb begin
    regRdData = 8'h00;
    for (int b = 0; b < COUNT_BYTES; b++) begin
      if (32'(regRdAddr) == b) regRdData = curCount[b*8 +: 8];
    end
    if ((32'(regRdAddr) == TOP_IDX) && !highWritten) regRdData = CHIP_ID;
  end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import xfer_cnt_pkg::*;
#(
  parameter int         COUNT_BYTES = 3,
  parameter logic [7:0] CHIP_ID     = 8'hA2,
  localparam int        ADDR_W      = (COUNT_BYTES < 2) ? 1 : $clog2(COUNT_BYTES + 1),
  localparam int        CNT_W       = COUNT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [7:0]        regRdData,
  input  logic              cmdStrobe,
  input  logic              cmdDmaFlag,
  input  logic              decReq,
  input  logic [CNT_W-1:0]  decAmount,
  input  logic              doneReq,
  output logic [CNT_W-1:0]  curCount,
  output logic              countZero,
  output logic              tcFlag,
  output logic              dmaMode
);
  xfer_strobe_t     strobe;
  logic             highWritten;
  logic             decHitsZero;
  logic [CNT_W-1:0] startCount;

  xfer_cnt_ctrl #(.COUNT_BYTES(COUNT_BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .cmdStrobe(cmdStrobe), .cmdDmaFlag(cmdDmaFlag), .decReq(decReq),
    .doneReq(doneReq), .decHitsZero(decHitsZero), .strobe(strobe),
    .tcFlag(tcFlag), .dmaMode(dmaMode), .highWritten(highWritten)
  );

  xfer_cnt_dp #(.COUNT_BYTES(COUNT_BYTES), .ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .decAmount(decAmount),
    .highWritten(highWritten), .regRdData(regRdData), .curCount(curCount),
    .startCount(startCount), .decHitsZero(decHitsZero)
  );

  assign countZero = (curCount == '0);
endmodule

// File: rtl/xfer_cnt_checker.sv
module xfer_cnt_checker #(
  parameter int COUNT_BYTES = 3,
  parameter int ADDR_W      = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     regWrEn,
  input logic [ADDR_W-1:0]        regAddr,
  input logic                     cmdStrobe,
  input logic                     cmdDmaFlag,
  input logic                     decReq,
  input logic [COUNT_BYTES*8-1:0] decAmount,
  input logic                     doneReq,
  input logic [COUNT_BYTES*8-1:0] curCount,
  input logic [COUNT_BYTES*8-1:0] startCount,
  input logic                     countZero,
  input logic                     tcFlag,
  input logic                     dmaMode
);
  localparam int CNT_W = COUNT_BYTES * 8;
  localparam logic [CNT_W-1:0] ZERO_RELOAD = CNT_W'(1) << (CNT_W - 8);

  logic isCountWr;
  assign isCountWr = regWrEn && (32'(regAddr) < COUNT_BYTES);

  // R2: a register write alone leaves the current count alone
  p_write_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !cmdStrobe && !decReq && !doneReq) |=> $stable(curCount));

  // R3 and R4: DMA reload of the start count, zero start loads 0x010000
  p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && cmdDmaFlag && !doneReq) |=>
      (dmaMode && curCount == (($past(startCount) == '0) ? ZERO_RELOAD : $past(startCount))));

  // R5: a command without the DMA flag keeps the count
  p_nodma_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && !cmdDmaFlag && !decReq && !doneReq) |=> (!dmaMode && $stable(curCount)));

  // R6: a count write with no set event clears terminal count
  p_wr_clears_tc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isCountWr && !decReq && !doneReq) |=> !tcFlag);

  // R8: subtraction below the count
  p_dec_sub_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decReq && !doneReq && !(cmdStrobe && cmdDmaFlag) && decAmount < curCount) |=>
      (curCount == $past(curCount) - $past(decAmount)));

  // R9: saturation at zero with terminal count
  p_dec_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decReq && !doneReq && !(cmdStrobe && cmdDmaFlag) && decAmount >= curCount) |=>
      (curCount == '0 && tcFlag));

  // R10: completion forces zero and terminal count
  p_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneReq |=> (curCount == '0 && tcFlag));

  // R12: zero flag rises only as the count reaches zero
  p_zero_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(countZero) |-> (curCount == '0));
endmodule

bind dma_xfer_counter xfer_cnt_checker #(.COUNT_BYTES(COUNT_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .cmdStrobe(cmdStrobe), .cmdDmaFlag(cmdDmaFlag), .decReq(decReq),
  .decAmount(decAmount), .doneReq(doneReq), .curCount(curCount),
  .startCount(startCount), .countZero(countZero), .tcFlag(tcFlag),
  .dmaMode(dmaMode)
);

// File: tb/sim_dma_xfer_counter.sv
`timescale 1ns/1ps
module sim_dma_xfer_counter;
  localparam logic [7:0] CHIP = 8'hA2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [7:0]  regWrData;
  logic [1:0]  regRdAddr;
  logic [7:0]  regRdData;
  logic        cmdStrobe;
  logic        cmdDmaFlag;
  logic        decReq;
  logic [23:0] decAmount;
  logic        doneReq;
  logic [23:0] curCount;
  logic        countZero;
  logic        tcFlag;
  logic        dmaMode;

  int tests = 0;
  int fails = 0;

  logic [23:0] expCount, expStart;
  logic        expTc, expDma, expHighW;

  always #2.5 clk = ~clk;

  dma_xfer_counter u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .cmdStrobe(cmdStrobe), .cmdDmaFlag(cmdDmaFlag), .decReq(decReq),
    .decAmount(decAmount), .doneReq(doneReq), .curCount(curCount),
    .countZero(countZero), .tcFlag(tcFlag), .dmaMode(dmaMode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    if (a == 2'd3) return 8'h00;
    if (a == 2'd2 && !expHighW) return CHIP;
    return expCount[a*8 +: 8];
  endfunction

  task automatic modelReset();
    expCount = '0; expStart = '0; expTc = 0; expDma = 0; expHighW = 0;
  endtask

  task automatic idle();
    regWrEn = 0; regAddr = 0; regWrData = 0; cmdStrobe = 0; cmdDmaFlag = 0;
    decReq = 0; decAmount = 0; doneReq = 0;
  endtask

  // Drive one cycle of requests, then update the bench model
  task automatic apply(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       input logic cmd, input logic dma, input logic dec,
                       input logic [23:0] amt, input logic done);
    logic [23:0] oldStart;
    logic setTc;
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d; cmdStrobe = cmd; cmdDmaFlag = dma;
    decReq = dec; decAmount = amt; doneReq = done;
    @(posedge clk);
    #1;
    oldStart = expStart;
    setTc = 0;
    if (wr && a != 2'd3) begin
      expStart[a*8 +: 8] = d;
      if (a == 2'd2) expHighW = 1;
    end
    if (done) begin
      expCount = '0; setTc = 1;
    end else if (cmd && dma) begin
      expCount = (oldStart == '0) ? 24'h010000 : oldStart;
    end else if (dec) begin
      if (amt >= expCount) begin expCount = '0; setTc = 1; end
      else expCount = expCount - amt;
    end
    if (setTc) expTc = 1;
    else if (wr && a != 2'd3) expTc = 0;
    if (cmd) expDma = dma;
    idle();
  endtask

  task automatic checkAll(input string req);
    chk({req, " count"}, 32'(curCount), 32'(expCount));
    chk({req, " tc"}, 32'(tcFlag), 32'(expTc));
    chk({req, " dma"}, 32'(dmaMode), 32'(expDma));
    chk("R12 zero flag", 32'(countZero), 32'(expCount == '0));
  endtask

  task automatic checkRead(input string req, input logic [1:0] a);
    regRdAddr = a;
    #1;
    chk(req, 32'(regRdData), 32'(expRead(a)));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    idle();
    @(posedge clk); @(posedge clk);
    #1;
    rstN = 1;
    modelReset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    rstN = 0; regRdAddr = 0;
    idle();
    doReset();

    // R1 reset state, R7 identification before first high write
    checkAll("R1 reset");
    checkRead("R7 id before write", 2'd2);

    // R2 byte loads go to start count only
    apply(1, 2'd0, 8'h34, 0, 0, 0, 0, 0); checkAll("R2 load low");
    apply(1, 2'd1, 8'h12, 0, 0, 0, 0, 0); checkAll("R2 load mid");
    apply(1, 2'd2, 8'h00, 0, 0, 0, 0, 0); checkAll("R2 load high");
    checkRead("R7 high after write", 2'd2);

    // R3 reload
    apply(0, 0, 0, 1, 1, 0, 0, 0); checkAll("R3 reload");
    checkRead("R3 read low", 2'd0);
    checkRead("R3 read mid", 2'd1);

    // R8 subtract, then exact hit
    apply(0, 0, 0, 0, 0, 1, 24'h34, 0); checkAll("R8 subtract");
    apply(0, 0, 0, 0, 0, 1, 24'h1200, 0); checkAll("R8 exact zero");

    // R6 count write clears tc
    apply(1, 2'd0, 8'h00, 0, 0, 0, 0, 0); checkAll("R6 write clears tc");

    // R5 non-DMA command
    apply(0, 0, 0, 1, 1, 0, 0, 0); checkAll("R5 setup");
    apply(0, 0, 0, 1, 0, 0, 0, 0); checkAll("R5 no dma");

    // R4 zero start loads 0x010000
    apply(1, 2'd1, 8'h00, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 1, 1, 0, 0, 0); checkAll("R4 zero start");
    chk("R4 value", 32'(curCount), 32'h010000);
    checkRead("R4 read high", 2'd2);

    // R9 saturation
    apply(0, 0, 0, 0, 0, 1, 24'h020000, 0); checkAll("R9 saturate");

    // R10 completion with coincident requests, R11 priority
    apply(0, 0, 0, 1, 1, 0, 0, 0);
    apply(1, 2'd0, 8'h55, 1, 1, 1, 24'h1, 1); checkAll("R10 done wins");
    apply(0, 0, 0, 1, 1, 1, 24'h5, 0); checkAll("R11 reload beats dec");
    apply(1, 2'd1, 8'h01, 0, 0, 1, 24'hFFFFFF, 0); checkAll("R11 set beats clear");

    // R13 unused address
    checkRead("R13 addr3", 2'd3);

    // R1 and R7 after a second reset
    doReset();
    checkAll("R1 second reset");
    checkRead("R7 id after reset", 2'd2);

    // R11 random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [23:0] amt;
      op  = 4'($urandom_range(0, 15));
      amt = ($urandom_range(0, 7) == 0) ? 24'($urandom) : 24'($urandom_range(0, 600));
      apply(op[0], 2'($urandom_range(0, 3)), 8'($urandom),
            op[1] && op[2], op[3], ($urandom_range(0, 2) != 0), amt,
            ($urandom_range(0, 19) == 0));
      checkAll("R11 random");
      checkRead("R7 random read", 2'($urandom_range(0, 3)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule